// File: doc/BRIEF.md
# Byte-Coded Register-Write Sequencer

This block is a self-running engine that steps through a short program of single-byte opcodes and their operand bytes. The program is held in a local word-wide store. From it the engine issues writes on a simple write-only register bus. It can also set or clear a bank of 32 output flags, stall until an external flag reaches a given level, and pause for a number of microseconds. A host uses it for timing-critical register sequences that software cannot pace reliably, such as reprogramming a memory clock.

The host first drops `eng_enable`, rewinds the load pointer and pushes the program one 32-bit word at a time. It then raises `eng_enable` and issues a start command. While the program runs, the host polls the busy bit of `status`. The program ends at a terminator byte. An illegal opcode, a run off the end of the store or a flag wait that never completes aborts the run and leaves a sticky error bit.

Two values persist between runs: the engine's address and data operand registers. An opcode that reloads only the low half of either register keeps the upper half from earlier instructions, even from earlier runs. Delays use a compact logarithmic encoding, counted against a prescaled microsecond tick.

Top module: `regseq_engine`

## Requirements
- R1: Host commands on `cmd_op` are 0 = rewind load pointer, 1 = store `cmd_word` at the pointer and advance it, 2 = start. Rewind and store are accepted only while `eng_enable` is low and the engine is idle. Program byte n is bits [8*(n%4)+7 : 8*(n%4)] of word n/4.
- R2: A start with `eng_enable` high and the engine idle sets `status[8]` (busy) on the next cycle, clears the error bits `status[2:0]` and executes from byte 0. A start with `eng_enable` low has no effect.
- R3: Byte 0xE2 loads the 32-bit data register from the next four bytes, least significant byte first; byte 0x42 replaces only its low 16 bits from the next two. Byte 0xE0 loads the full address register from the next four bytes and 0x40 only its low 16 bits from the next two. Each address opcode then drives exactly one single-cycle `bus_wr_valid` pulse carrying the new address and the current data register.
- R4: Bytes 0xC0-0xDF set `flags_out[op & 0x1F]` to 1, bytes 0xA0-0xBF clear it to 0, and bytes 0x80-0x9F leave it unchanged.
- R5: Byte 0x5F is followed by a flag index byte and a value byte, where a nonzero value byte means 1. The engine stalls until `flag_in[index]` equals that value. When they already match, the wait costs one cycle.
- R6: A byte 0x00-0x3F is a delay of (op & 3) x 4^((op >> 2) & 0xF) microseconds, with one microsecond equal to `CYC_PER_US` clock cycles. A nonzero delay of N microseconds keeps the engine busy exactly N x `CYC_PER_US` cycles longer than a zero-count delay byte, which costs one cycle.
- R7: Byte 0x7F ends the run: busy clears on the cycle after it is reached and no error bit is set. A program that is only 0x7F is busy for one cycle.
- R8: Any byte not defined in R3-R7 stops the engine and sets `status[0]`. Bytes after it are not executed.
- R9: Fetching past the last program word stops the engine and sets `status[1]`.
- R10: When a flag wait has seen a mismatch on `wait_limit`+1 consecutive cycles, the engine aborts and sets `status[2]`.
- R11: Both operand registers reset to all ones and keep their values between runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| eng_enable | input | 1 | Engine enable level |
| cmd_valid | input | 1 | Host command strobe |
| cmd_op | input | 2 | Host command code (R1) |
| cmd_word | input | 32 | Program word for a store command |
| wait_limit | input | WAIT_W | Flag-wait timeout in cycles |
| flag_in | input | 32 | External flag levels sampled by waits |
| bus_wr_valid | output | 1 | Register write strobe |
| bus_wr_addr | output | 32 | Register write address |
| bus_wr_data | output | 32 | Register write data |
| flags_out | output | 32 | Flag bank driven by flag opcodes |
| status | output | 32 | Bit 8 busy, bit 2 wait timeout, bit 1 overrun, bit 0 bad opcode |

## Verification
One write program mixes full and half-width loads of both operand registers. Its write log shows the byte order within a word, the retention of upper halves, and the rule that data loads alone issue no write. Flag programs set, clear and no-op the same index in sequence, which separates the three flag ranges from one another. Delay programs with different mantissa and exponent fields, timed against a zero-count delay, separate an error in the shift amount from an error in the multiplier. Wait programs are tried with a match already present, with a match arriving late and with no match at all, so the stall, the release and the timeout each show up in the busy length.

// File: rtl/regseq_pkg.sv
package regseq_pkg;

    typedef enum logic [1:0] {
        CMD_REWIND = 2'd0,
        CMD_STORE  = 2'd1,
        CMD_START  = 2'd2,
        CMD_NONE   = 2'd3
    } host_cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_EXEC,
        ST_OPND,
        ST_DELAY,
        ST_WAIT
    } seq_state_e;

    localparam logic [7:0] OP_END       = 8'h7F;
    localparam logic [7:0] OP_DATA_FULL = 8'hE2;
    localparam logic [7:0] OP_DATA_LOW  = 8'h42;
    localparam logic [7:0] OP_ADDR_FULL = 8'hE0;
    localparam logic [7:0] OP_ADDR_LOW  = 8'h40;
    localparam logic [7:0] OP_WAIT      = 8'h5F;

    localparam int FLAG_COUNT = 32;
    localparam int BUSY_BIT   = 8;
    localparam int ERR_BADOP  = 0;
    localparam int ERR_RUNOFF = 1;
    localparam int ERR_TMO    = 2;
    localparam logic [31:0] EMPTY_WORD = 32'h7F7F7F7F;

    typedef struct packed {
        logic [31:0] addr;
        logic [31:0] data;
    } operand_regs_t;

    // microseconds encoded by a delay byte: mantissa op[1:0], base-4 exponent op[5:2]
    function automatic logic [31:0] delay_count(input logic [7:0] op);
        return {30'd0, op[1:0]} << {op[5:2], 1'b0};
    endfunction

    function automatic logic takes_operands(input logic [7:0] op);
        return (op == OP_DATA_FULL) || (op == OP_DATA_LOW) ||
               (op == OP_ADDR_FULL) || (op == OP_ADDR_LOW) || (op == OP_WAIT);
    endfunction

endpackage

// File: rtl/regseq_progmem.sv
module regseq_progmem #(
    parameter int WORDS = 64,
    localparam int AW = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_idx,
    input  logic [31:0]   wr_word,
    input  logic [AW+1:0] rd_byte_addr,
    output logic [7:0]    rd_byte
);
    import regseq_pkg::*;

    logic [31:0] mem [WORDS];
    logic [31:0] rd_word;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < WORDS; i++) mem[i] <= EMPTY_WORD;
        end else if (wr_en) begin
            mem[wr_idx] <= wr_word;
        end
    end

    always_comb begin
        rd_word = mem[rd_byte_addr[AW+1:2]];
        rd_byte = rd_word[{rd_byte_addr[1:0], 3'b000} +: 8];
    end

endmodule

// File: rtl/regseq_usdelay.sv
module regseq_usdelay #(
    parameter int CYC_PER_US = 100
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        load,
    input  logic [31:0] count,
    output logic        finishing
);
    logic        active;
    logic [31:0] us_left;
    logic        tick;

    generate
        if (CYC_PER_US == 1) begin : g_noprescale
            assign tick = 1'b1;
        end else begin : g_prescale
            localparam int PW = $clog2(CYC_PER_US);
            localparam logic [PW-1:0] PRE_LAST = PW'(CYC_PER_US - 1);
            logic [PW-1:0] pre;
            always_ff @(posedge clk) begin
                if (rst || !active || pre == PRE_LAST) pre <= '0;
                else                                   pre <= pre + 1'b1;
            end
            assign tick = (pre == PRE_LAST);
        end
    endgenerate

    assign finishing = active && tick && (us_left == 32'd1);

    always_ff @(posedge clk) begin
        if (rst) begin
            active  <= 1'b0;
            us_left <= '0;
        end else if (load && count != 32'd0) begin
            active  <= 1'b1;
            us_left <= count;
        end else if (finishing) begin
            active  <= 1'b0;
        end else if (active && tick) begin
            us_left <= us_left - 32'd1;
        end
    end

endmodule

// File: rtl/regseq_ctrl.sv
module regseq_ctrl #(
    parameter int WORDS  = 64,
    parameter int WAIT_W = 16,
    localparam int AW  = $clog2(WORDS),
    localparam int PCW = AW + 3
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                start,
    output logic [PCW-1:0]                      pc,
    input  logic [7:0]                          fetch_byte,
    input  logic [regseq_pkg::FLAG_COUNT-1:0]   flag_in,
    input  logic [WAIT_W-1:0]                   wait_limit,
    output logic                                dly_load,
    output logic [31:0]                         dly_count,
    input  logic                                dly_done,
    output logic                                wr_valid,
    output regseq_pkg::operand_regs_t           opregs,
    output logic [regseq_pkg::FLAG_COUNT-1:0]   flags,
    output logic                                busy,
    output logic [2:0]                          err
);
    import regseq_pkg::*;

    seq_state_e  st;
    logic [7:0]  opc;
    logic [1:0]  oidx;
    logic [31:0] obuf, obuf_nx;
    logic [4:0]  w_idx;
    logic        w_val;
    logic [WAIT_W-1:0] tmo;
    logic        runoff, opnd_last;

    assign runoff    = pc[PCW-1];
    assign busy      = (st != ST_IDLE);
    assign opnd_last = opc[7] ? (oidx == 2'd3) : (oidx == 2'd1);
    assign dly_load  = (st == ST_EXEC) && !runoff && (fetch_byte[7:6] == 2'b00);
    assign dly_count = delay_count(fetch_byte);

    always_comb begin
        obuf_nx = obuf;
        obuf_nx[{oidx, 3'b000} +: 8] = fetch_byte;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            pc       <= '0;
            opc      <= '0;
            oidx     <= '0;
            obuf     <= '0;
            w_idx    <= '0;
            w_val    <= 1'b0;
            tmo      <= '0;
            wr_valid <= 1'b0;
            opregs   <= '{addr: 32'hFFFF_FFFF, data: 32'hFFFF_FFFF};
            flags    <= '0;
            err      <= '0;
        end else begin
            wr_valid <= 1'b0;
            unique case (st)
                ST_IDLE: begin
                    if (start) begin
                        st  <= ST_EXEC;
                        pc  <= '0;
                        err <= '0;
                    end
                end
                ST_EXEC: begin
                    if (runoff) begin
                        err[ERR_RUNOFF] <= 1'b1;
                        st <= ST_IDLE;
                    end else begin
                        pc <= pc + 1'b1;
                        if (fetch_byte == OP_END) begin
                            st <= ST_IDLE;
                        end else if (fetch_byte[7:6] == 2'b00) begin
                            if (dly_count != 32'd0) st <= ST_DELAY;
                        end else if (fetch_byte[7:5] == 3'b100) begin
                            st <= ST_EXEC;
                        end else if (fetch_byte[7:5] == 3'b101) begin
                            flags[fetch_byte[4:0]] <= 1'b0;
                        end else if (fetch_byte[7:5] == 3'b110) begin
                            flags[fetch_byte[4:0]] <= 1'b1;
                        end else if (takes_operands(fetch_byte)) begin
                            opc  <= fetch_byte;
                            oidx <= '0;
                            st   <= ST_OPND;
                        end else begin
                            err[ERR_BADOP] <= 1'b1;
                            st <= ST_IDLE;
                        end
                    end
                end
                ST_OPND: begin
                    if (runoff) begin
                        err[ERR_RUNOFF] <= 1'b1;
                        st <= ST_IDLE;
                    end else begin
                        pc   <= pc + 1'b1;
                        obuf <= obuf_nx;
                        oidx <= oidx + 1'b1;
                        if (opnd_last) begin
                            st <= ST_EXEC;
                            case (opc)
                                OP_DATA_FULL: opregs.data <= obuf_nx;
                                OP_DATA_LOW:  opregs.data[15:0] <= obuf_nx[15:0];
                                OP_ADDR_FULL: begin
                                    opregs.addr <= obuf_nx;
                                    wr_valid    <= 1'b1;
                                end
                                OP_ADDR_LOW: begin
                                    opregs.addr[15:0] <= obuf_nx[15:0];
                                    wr_valid          <= 1'b1;
                                end
                                default: begin
                                    w_idx <= obuf_nx[4:0];
                                    w_val <= |obuf_nx[15:8];
                                    tmo   <= '0;
                                    st    <= ST_WAIT;
                                end
                            endcase
                        end
                    end
                end
                ST_DELAY: begin
                    if (dly_done) st <= ST_EXEC;
                end
                ST_WAIT: begin
                    if (flag_in[w_idx] == w_val) begin
                        st <= ST_EXEC;
                    end else if (tmo == wait_limit) begin
                        err[ERR_TMO] <= 1'b1;
                        st <= ST_IDLE;
                    end else begin
                        tmo <= tmo + 1'b1;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/regseq_engine.sv
module regseq_engine #(
    parameter int PROG_WORDS = 64,
    parameter int CYC_PER_US = 100,
    parameter int WAIT_W     = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              eng_enable,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [31:0]       cmd_word,
    input  logic [WAIT_W-1:0] wait_limit,
    input  logic [31:0]       flag_in,
    output logic              bus_wr_valid,
    output logic [31:0]       bus_wr_addr,
    output logic [31:0]       bus_wr_data,
    output logic [31:0]       flags_out,
    output logic [31:0]       status
);
    import regseq_pkg::*;

    localparam int AW  = $clog2(PROG_WORDS);
    localparam int PCW = AW + 3;

    logic [AW:0]    ld_ptr;
    logic           busy, host_ok, do_store, do_start;
    logic [PCW-1:0] pc;
    logic [7:0]     fetch_byte;
    logic           dly_load, dly_done;
    logic [31:0]    dly_count;
    logic [2:0]     err;
    operand_regs_t  opregs;

    assign host_ok  = cmd_valid && !eng_enable && !busy;
    assign do_store = host_ok && (cmd_op == CMD_STORE) && !ld_ptr[AW];
    assign do_start = cmd_valid && eng_enable && !busy && (cmd_op == CMD_START);

    always_ff @(posedge clk) begin
        if (rst)                                        ld_ptr <= '0;
        else if (host_ok && cmd_op == CMD_REWIND)       ld_ptr <= '0;
        else if (do_store)                              ld_ptr <= ld_ptr + 1'b1;
    end

    regseq_progmem #(.WORDS(PROG_WORDS)) u_mem (
        .clk          (clk),
        .rst          (rst),
        .wr_en        (do_store),
        .wr_idx       (ld_ptr[AW-1:0]),
        .wr_word      (cmd_word),
        .rd_byte_addr (pc[AW+1:0]),
        .rd_byte      (fetch_byte)
    );

    regseq_usdelay #(.CYC_PER_US(CYC_PER_US)) u_dly (
        .clk       (clk),
        .rst       (rst),
        .load      (dly_load),
        .count     (dly_count),
        .finishing (dly_done)
    );

    regseq_ctrl #(.WORDS(PROG_WORDS), .WAIT_W(WAIT_W)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start      (do_start),
        .pc         (pc),
        .fetch_byte (fetch_byte),
        .flag_in    (flag_in),
        .wait_limit (wait_limit),
        .dly_load   (dly_load),
        .dly_count  (dly_count),
        .dly_done   (dly_done),
        .wr_valid   (bus_wr_valid),
        .opregs     (opregs),
        .flags      (flags_out),
        .busy       (busy),
        .err        (err)
    );

    assign bus_wr_addr = opregs.addr;
    assign bus_wr_data = opregs.data;

    always_comb begin
        status           = '0;
        status[BUSY_BIT] = busy;
        status[2:0]      = err;
    end

endmodule

// File: rtl/regseq_engine_chk.sv
module regseq_engine_chk (
    input logic        clk,
    input logic        rst,
    input logic        eng_enable,
    input logic        cmd_valid,
    input logic [1:0]  cmd_op,
    input logic        bus_wr_valid,
    input logic [31:0] flags_out,
    input logic [31:0] status
);
    assert_start_runs_R2: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == 2'd2 && eng_enable && !status[8]) |=> status[8]);

    assert_start_blocked_R2: assert property (@(posedge clk) disable iff (rst)
        (!status[8] && !(cmd_valid && cmd_op == 2'd2 && eng_enable)) |=> !status[8]);

    assert_write_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        bus_wr_valid |=> !bus_wr_valid);

    assert_write_in_run_R3: assert property (@(posedge clk) disable iff (rst)
        bus_wr_valid |-> status[8]);

    assert_flags_idle_R4: assert property (@(posedge clk) disable iff (rst)
        !status[8] |=> $stable(flags_out));

    assert_badop_stops_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(status[0]) |-> $fell(status[8]));

    assert_runoff_stops_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(status[1]) |-> $fell(status[8]));

    assert_timeout_stops_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(status[2]) |-> $fell(status[8]));
endmodule

bind regseq_engine regseq_engine_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .eng_enable   (eng_enable),
    .cmd_valid    (cmd_valid),
    .cmd_op       (cmd_op),
    .bus_wr_valid (bus_wr_valid),
    .flags_out    (flags_out),
    .status       (status)
);

// File: tb/regseq_engine_test.sv
module regseq_engine_test;
    localparam int CYC = 100;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        eng_enable = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'd3;
    logic [31:0] cmd_word = '0;
    logic [15:0] wait_limit = 16'd1000;
    logic [31:0] flag_in = '0;
    logic        bus_wr_valid;
    logic [31:0] bus_wr_addr, bus_wr_data, flags_out, status;

    int nchk = 0, nerr = 0, nw = 0, pn = 0;
    logic [31:0] wa [0:15];
    logic [31:0] wd [0:15];
    logic [7:0]  pb [0:511];
    bit done = 0;

    regseq_engine #(.PROG_WORDS(64), .CYC_PER_US(CYC), .WAIT_W(16)) uut (.*);

    always #5 clk = ~clk;

    always @(negedge clk) if (bus_wr_valid && nw < 16) begin
        wa[nw] = bus_wr_addr; wd[nw] = bus_wr_data; nw++;
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic host(input logic [1:0] op, input logic [31:0] w);
        @(negedge clk); cmd_valid = 1'b1; cmd_op = op; cmd_word = w;
        @(negedge clk); cmd_valid = 1'b0; cmd_op = 2'd3;
    endtask

    task automatic b(input logic [7:0] v);
        pb[pn] = v; pn++;
    endtask

    task automatic load_prog();
        host(2'd0, '0);
        for (int w = 0; w < (pn + 3) / 4; w++) begin
            logic [31:0] word;
            for (int k = 0; k < 4; k++)
                word[8*k +: 8] = (4*w + k < pn) ? pb[4*w + k] : 8'h7F;
            host(2'd1, word);
        end
        pn = 0;
    endtask

    task automatic run_prog(output int cyc);
        @(negedge clk); eng_enable = 1'b1;
        host(2'd2, '0);
        cyc = 0;
        while (status[8] && cyc < 30000) begin cyc++; @(negedge clk); end
        eng_enable = 1'b0;
    endtask

    task automatic t_reset();
        check("R11 reset status", status, 32'h0);
        check("R11 reset wr_valid", {31'd0, bus_wr_valid}, 32'h0);
        check("R4 reset flags", flags_out, 32'h0);
    endtask

    task automatic t_reset_operands();
        int c;
        nw = 0;
        b(8'h40); b(8'h34); b(8'h12); b(8'h7F);
        load_prog(); run_prog(c);
        check("R11 write count", nw, 1);
        check("R11 addr upper kept from reset", wa[0], 32'hFFFF1234);
        check("R11 data reset value", wd[0], 32'hFFFFFFFF);
    endtask

    task automatic t_writes();
        int c;
        nw = 0;
        b(8'hE2); b(8'h78); b(8'h56); b(8'h34); b(8'h12);
        b(8'hE0); b(8'h00); b(8'h10); b(8'h05); b(8'h00);
        b(8'h42); b(8'hCD); b(8'hAB);
        b(8'h40); b(8'h04); b(8'h10);
        b(8'h40); b(8'h08); b(8'h10); b(8'h7F);
        load_prog(); run_prog(c);
        check("R3 write count", nw, 3);
        check("R3 full addr", wa[0], 32'h00051000);
        check("R1 R3 full data byte order", wd[0], 32'h12345678);
        check("R3 low addr", wa[1], 32'h00051004);
        check("R3 low data", wd[1], 32'h1234ABCD);
        check("R3 repeat addr", wa[2], 32'h00051008);
        check("R3 repeat data", wd[2], 32'h1234ABCD);
        check("R7 no error", status, 32'h0);
        nw = 0;
        b(8'h40); b(8'h20); b(8'h00); b(8'h7F);
        load_prog(); run_prog(c);
        check("R11 addr upper across runs", wa[0], 32'h00050020);
        check("R11 data across runs", wd[0], 32'h1234ABCD);
    endtask

    task automatic t_flags();
        int c;
        b(8'hC1); b(8'hC5); b(8'hA5); b(8'h85); b(8'h81); b(8'h7F);
        load_prog(); run_prog(c);
        check("R4 set then noop keeps 1", {31'd0, flags_out[1]}, 32'd1);
        check("R4 clear then noop keeps 0", {31'd0, flags_out[5]}, 32'd0);
    endtask

    task automatic t_end_and_ignore();
        int c;
        b(8'h7F);
        load_prog(); run_prog(c);
        check("R7 end busy cycles", c, 1);
        // start while disabled
        host(2'd2, '0);
        check("R2 start ignored when disabled", {31'd0, status[8]}, 32'd0);
        // store while enabled must not reach the program
        b(8'hA2); b(8'h7F);
        load_prog();
        @(negedge clk); eng_enable = 1'b1;
        host(2'd0, '0);
        host(2'd1, 32'h7F7F7FC2);
        eng_enable = 1'b0;
        run_prog(c);
        check("R1 store ignored while enabled", {31'd0, flags_out[2]}, 32'd0);
    endtask

    task automatic t_delay();
        int c0, c1, c2, c3;
        b(8'h00); b(8'h7F); load_prog(); run_prog(c0);
        check("R6 zero delay cost", c0, 2);
        b(8'h06); b(8'h7F); load_prog(); run_prog(c1);
        check("R6 delay 2x4us", c1 - c0, 8 * CYC);
        b(8'h0B); b(8'h7F); load_prog(); run_prog(c2);
        check("R6 delay 3x16us", c2 - c0, 48 * CYC);
        b(8'h3C); b(8'h7F); load_prog(); run_prog(c3);
        check("R6 zero mantissa", c3, c0);
    endtask

    task automatic t_wait();
        int c;
        wait_limit = 16'd1000;
        flag_in = '0;
        b(8'h5F); b(8'h04); b(8'h00); b(8'h7F);
        load_prog(); run_prog(c);
        check("R5 immediate match cycles", c, 5);
        b(8'h5F); b(8'h03); b(8'h01); b(8'hC9); b(8'h7F);
        load_prog();
        @(negedge clk); eng_enable = 1'b1;
        host(2'd2, '0);
        repeat (30) @(negedge clk);
        check("R5 stalled busy", {31'd0, status[8]}, 32'd1);
        check("R5 stalled no flag", {31'd0, flags_out[9]}, 32'd0);
        flag_in[3] = 1'b1;
        repeat (5) @(negedge clk);
        eng_enable = 1'b0;
        check("R5 released", status, 32'h0);
        check("R5 continued", {31'd0, flags_out[9]}, 32'd1);
        flag_in = '0;
    endtask

    task automatic t_timeout();
        int c;
        wait_limit = 16'd40;
        b(8'h5F); b(8'h03); b(8'h01); b(8'h7F);
        load_prog(); run_prog(c);
        check("R10 timeout status", status, 32'h4);
        check("R10 timeout cycles", c, 44);
        wait_limit = 16'd1000;
    endtask

    task automatic t_badop();
        int c;
        b(8'hC7); b(8'h41); b(8'hC6); b(8'h7F);
        load_prog(); run_prog(c);
        check("R8 bad opcode status", status, 32'h1);
        check("R8 before executed", {31'd0, flags_out[7]}, 32'd1);
        check("R8 after skipped", {31'd0, flags_out[6]}, 32'd0);
        b(8'h7F); load_prog(); run_prog(c);
        check("R2 start clears errors", status, 32'h0);
    endtask

    task automatic t_runoff();
        int c;
        for (int i = 0; i < 256; i++) b(8'h80);
        load_prog(); run_prog(c);
        check("R9 runoff status", status, 32'h2);
        check("R9 runoff cycles", c, 257);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_reset_operands();
        t_writes();
        t_flags();
        t_end_and_ignore();
        t_delay();
        t_wait();
        t_timeout();
        t_badop();
        t_runoff();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
            $finish;
        end
    end

    initial begin
        #1500000;
        if (!done) begin
            done = 1;
            nchk++; nerr++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
            $finish;
        end
    end
endmodule